// File: doc/BRIEF.md
# Posted Write Buffer with Read Forwarding

This block sits between a command port and a single-port storage array that accepts one access per clock, either a read or a write. Every write is held back in a one-entry pending register. It reaches the array only when the next write command arrives. On that later write cycle the held entry is committed to the array, and the incoming write takes its place in the pending register in the same cycle. Read commands always use the array port at once, so a read never waits behind a write.

The array still holds stale contents while a write is pending. For that reason the address of every read is compared with the pending entry. On a match, the lanes that the held write enabled are taken from the buffer and the remaining lanes come from the array. The read result appears one cycle after the read command. The array port returns read data in the cycle after the access.

Top module: `posted_wbuf`

## Requirements
- R1: While `rst_n` is low, and after reset until the first write, no write entry is pending. The first write after reset causes no array write.
- R2: A write command is never written to the array in its own cycle. Any array write carries the address, data and byte enables of the write command that came before the current one.
- R3: A held write stays pending through any number of read or idle cycles. It is committed (`arr_en`=1, `arr_we`=1) in the cycle of the next write command (`cmd_valid`=1, `cmd_wr`=1).
- R4: A read command (`cmd_valid`=1, `cmd_wr`=0) drives `arr_en`=1, `arr_we`=0 and `arr_addr`=`cmd_addr` in the same cycle. `rd_valid` is high exactly one cycle after each read command and low otherwise.
- R5: If a read address equals the pending write address, then for every lane i with held enable bit i = 1, bits [8i+7:8i] of `rd_data` come from the held data. All other lanes come from the array.
- R6: A read that does not match the pending address returns `arr_rdata` unchanged.
- R7: While no write is pending, a read is never forwarded, even if its address equals the pending register's reset value of 0.
- R8: If two successive writes target the same address, a following read returns the second write's bytes on the lanes it enabled and the first write's bytes on the remaining lanes.
- R9: A cycle with `cmd_valid`=0 makes no array access (`arr_en`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Command word address |
| cmd_data | input | NB*8 | Write data |
| cmd_be | input | NB | Write byte enables, bit i covers data bits [8i+7:8i] |
| arr_en | output | 1 | Array access this cycle |
| arr_we | output | 1 | Array access is a write |
| arr_addr | output | AW | Array address |
| arr_wdata | output | NB*8 | Array write data |
| arr_be | output | NB | Array write byte enables |
| arr_rdata | input | NB*8 | Array read data, valid the cycle after a read access |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | NB*8 | Read result after forwarding merge |

## Verification
Two functions can meet in one cycle. The first is the return of a forwarded read. The second is a write that commits the old pending entry and replaces it with a new one, so the read result must still reflect the entry that was pending when the read was issued. The bench provokes this with a read followed at once by a write to the same address, and also produces it often in a long random stream confined to eight addresses. A golden memory, updated in command order, gives the expected value of every read. Each cycle's array access is compared with the command history kept by the bench.

// File: rtl/posted_wbuf.sv
module posted_wbuf #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_wr,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [NB*8-1:0]   cmd_data,
  input  logic [NB-1:0]     cmd_be,
  output logic              arr_en,
  output logic              arr_we,
  output logic [AW-1:0]     arr_addr,
  output logic [NB*8-1:0]   arr_wdata,
  output logic [NB-1:0]     arr_be,
  input  logic [NB*8-1:0]   arr_rdata,
  output logic              rd_valid,
  output logic [NB*8-1:0]   rd_data
);
  localparam int DW = NB * 8;

  logic          pend_v;
  logic [AW-1:0] pend_a;
  logic [DW-1:0] pend_d;
  logic [NB-1:0] pend_be;

  logic          rv_q;
  logic [DW-1:0] fwd_d;
  logic [NB-1:0] fwd_be;

  logic wr, rd, hit;

  assign wr  = cmd_valid & cmd_wr;
  assign rd  = cmd_valid & ~cmd_wr;
  assign hit = rd & pend_v & (cmd_addr == pend_a);

  assign arr_en    = rd | (wr & pend_v);
  assign arr_we    = wr & pend_v;
  assign arr_addr  = wr ? pend_a : cmd_addr;
  assign arr_wdata = pend_d;
  assign arr_be    = pend_be;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v  <= 1'b0;
      pend_a  <= '0;
      pend_d  <= '0;
      pend_be <= '0;
    end else if (wr) begin
      pend_v  <= 1'b1;
      pend_a  <= cmd_addr;
      pend_d  <= cmd_data;
      pend_be <= cmd_be;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q   <= 1'b0;
      fwd_d  <= '0;
      fwd_be <= '0;
    end else begin
      rv_q   <= rd;
      fwd_d  <= pend_d;
      fwd_be <= hit ? pend_be : '0;
    end
  end

  assign rd_valid = rv_q;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign rd_data[i*8 +: 8] = fwd_be[i] ? fwd_d[i*8 +: 8] : arr_rdata[i*8 +: 8];
  end
endmodule

// File: rtl/posted_wbuf_chk.sv
module posted_wbuf_chk #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_wr,
  input logic [AW-1:0]     cmd_addr,
  input logic [NB*8-1:0]   cmd_data,
  input logic [NB-1:0]     cmd_be,
  input logic              arr_en,
  input logic              arr_we,
  input logic [AW-1:0]     arr_addr,
  input logic [NB*8-1:0]   arr_wdata,
  input logic [NB-1:0]     arr_be,
  input logic [NB*8-1:0]   arr_rdata,
  input logic              rd_valid,
  input logic [NB*8-1:0]   rd_data
);
  logic          seen;
  logic [AW-1:0] last_a;
  logic [NB*8-1:0] last_d;
  logic [NB-1:0] last_be;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0; last_a <= '0; last_d <= '0; last_be <= '0;
    end else if (cmd_valid && cmd_wr) begin
      seen <= 1'b1; last_a <= cmd_addr; last_d <= cmd_data; last_be <= cmd_be;
    end
  end

  AST_FIRST_WR_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_wr && !seen) |-> !arr_we); // R1
  AST_COMMIT_IS_PREV: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_addr == last_a && arr_wdata == last_d && arr_be == last_be)); // R2
  AST_COMMIT_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_wr && seen) |-> (arr_en && arr_we)); // R3
  AST_RD_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_wr) |-> (arr_en && !arr_we && arr_addr == cmd_addr)); // R4
  AST_RD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_wr) |=> rd_valid); // R4
  AST_NO_SPURIOUS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && !cmd_wr) |=> !rd_valid); // R4
  AST_MISS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_wr && !(seen && cmd_addr == last_a)) |=> (rd_data == arr_rdata)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> !arr_en); // R9
endmodule

bind posted_wbuf posted_wbuf_chk #(.AW(AW), .NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
  .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_be(cmd_be),
  .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr),
  .arr_wdata(arr_wdata), .arr_be(arr_be), .arr_rdata(arr_rdata),
  .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/posted_wbuf_tb.sv
module posted_wbuf_tb;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = NB * 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_wr = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic [NB-1:0] cmd_be = '0;
  logic arr_en, arr_we, rd_valid;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata, rd_data;
  logic [NB-1:0] arr_be;
  logic [DW-1:0] arr_rdata;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  posted_wbuf #(.AW(AW), .NB(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_be(cmd_be),
    .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_be(arr_be), .arr_rdata(arr_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] pattern(int i);
    return DW'(32'hA5C30000 ^ (i * 32'h01030507));
  endfunction

  logic [DW-1:0] mem [DEPTH];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= pattern(i);
      arr_rdata <= '0;
    end else if (arr_en) begin
      if (arr_we) begin
        for (int b = 0; b < NB; b++)
          if (arr_be[b]) mem[arr_addr][b*8 +: 8] <= arr_wdata[b*8 +: 8];
      end else begin
        arr_rdata <= mem[arr_addr];
      end
    end
  end

  logic [DW-1:0] gold [DEPTH];
  bit have_prev = 0, have_prev2 = 0;
  logic [AW-1:0] prev_a = '0, prev2_a = '0;
  logic [DW-1:0] prev_d = '0;
  logic [NB-1:0] prev_be = '0;
  bit exp_rv = 0;
  logic [DW-1:0] exp_rd = '0;
  string exp_tag = "R4";

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input bit w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [NB-1:0] be);
    @(negedge clk);
    chk(rd_valid == exp_rv, "R4", DW'(rd_valid), DW'(exp_rv));
    if (exp_rv) chk(rd_data == exp_rd, exp_tag, rd_data, exp_rd);
    cmd_valid = v; cmd_wr = w; cmd_addr = a; cmd_data = d; cmd_be = be;
    #1;
    if (!v) begin
      chk(!arr_en, "R9", DW'(arr_en), '0);
      exp_rv = 0;
    end else if (!w) begin
      chk(arr_en && !arr_we && arr_addr == a, "R4", DW'(arr_addr), DW'(a));
      exp_rv = 1;
      exp_rd = gold[a];
      if (!have_prev) exp_tag = "R7";
      else if (a != prev_a) exp_tag = "R6";
      else if (have_prev2 && prev2_a == prev_a) exp_tag = "R8";
      else exp_tag = "R5";
    end else begin
      exp_rv = 0;
      if (!have_prev) chk(!arr_we, "R1", DW'(arr_we), '0);
      else begin
        chk(arr_en && arr_we, "R3", DW'({arr_en, arr_we}), DW'(2'b11));
        chk(arr_addr == prev_a && arr_wdata == prev_d && arr_be == prev_be, "R2",
            arr_wdata, prev_d);
      end
      for (int b = 0; b < NB; b++) if (be[b]) gold[a][b*8 +: 8] = d[b*8 +: 8];
      have_prev2 = have_prev; prev2_a = prev_a;
      have_prev = 1; prev_a = a; prev_d = d; prev_be = be;
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) gold[i] = pattern(i);
    repeat (3) @(negedge clk);
    chk(!rd_valid && !arr_en, "R1", DW'({rd_valid, arr_en}), '0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 0, 6'd0, '0, '0);
    step(1, 0, 6'd0, '0, '0);
    step(1, 1, 6'd5, 32'h11223344, 4'hF);
    step(1, 0, 6'd5, '0, '0);
    step(1, 0, 6'd5, '0, '0);
    step(0, 0, 6'd0, '0, '0);
    step(1, 0, 6'd5, '0, '0);
    step(1, 1, 6'd9, 32'hDEADBEEF, 4'b0101);
    step(1, 0, 6'd9, '0, '0);
    step(1, 0, 6'd5, '0, '0);
    step(1, 1, 6'd9, 32'h0BADF00D, 4'b1010);
    step(1, 0, 6'd9, '0, '0);
    step(1, 1, 6'd9, 32'h55667788, 4'b0011);
    step(1, 0, 6'd9, '0, '0);
    step(1, 1, 6'd9, 32'h99AABBCC, 4'b1111);
    step(1, 0, 6'd9, '0, '0);
    step(1, 1, 6'd3, 32'h12345678, 4'b0000);
    step(1, 0, 6'd3, '0, '0);
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[2], {3'b000, r[5:3]}, $urandom, r[9:6]);
    end
    step(0, 0, 6'd0, '0, '0);
    step(0, 0, 6'd0, '0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule